// File: doc/BRIEF.md
# Multi-Stream Stride Prefetcher

The block watches the demand loads that a core issues and learns the regular patterns in them. It keeps a small table of streams. Each stream records the last cache line it touched, the step in lines between its last two distinct lines, and a two-bit confidence counter. Once a stream has shown the same step often enough, every load that continues the stream asks for the line that lies a fixed number of steps ahead. The demand stream then finds that line already on its way. Byte addresses are cut into 64-byte lines, so one line holds eight 64-bit words.

A load matches a stream when its line lies within a bounded window of that stream's last line. A load that matches no stream takes over the least recently used entry. Jumps larger than the window never form a stride, so large or scattered jumps never trigger a request. Dependent loads with irregular steps reset the confidence again and again, so they do not trigger requests either. Requests leave through a single valid/ready register that carries a line address. A request that arrives while that register is stalled is dropped. A stream does not ask twice in a row for the same line.

Top module: `stride_prefetcher`

## Requirements
- R1: During reset and on the first cycle after it, `pf_valid` is low, and every table entry is empty.
- R2: The line address is the byte address shifted right by 6. A load to the same line as its stream's last load leaves the stride and the confidence unchanged.
- R3: With unit-stride line accesses, the 4th access of a new stream is the first to raise `pf_valid`. This happens on the cycle after the load, with `pf_line` = line + PF_DIST (default 2).
- R4: The confidence is a saturating 0..3 counter. A repeated step raises it and a different step lowers it and becomes the new stride. A request is made only when the step repeats and the updated confidence is 2 or more. Loads whose steps keep changing never request.
- R5: Negative strides are learned in the same way as positive ones.
- R6: A load whose line differs from every stream's last line by more than MAX_STRIDE lines (default 64, i.e. 4 KB) starts a new stream. A run of such jumps produces no request.
- R7: Up to NUM_STREAMS (default 4) streams train independently when their loads are interleaved.
- R8: A load that matches no stream replaces the least recently used entry. The stream that was evicted must then train again from zero confidence.
- R9: A load to the same line on a confident stream requests the line stride×PF_DIST ahead of it, unless that stream's last issued request was for that same line. In that case nothing is issued.
- R10: While `pf_valid` is high and `pf_ready` is low, `pf_line` holds its value. A request made in that state is dropped, and the stream does not record it as issued.
- R11: Every request targets the load's line plus stride × PF_DIST, so it lies within MAX_STRIDE×PF_DIST lines of that load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | A demand load is present this cycle |
| ld_addr | input | ADDR_W | Byte address of the demand load |
| pf_valid | output | 1 | A prefetch request is offered |
| pf_ready | input | 1 | The consumer takes the offered request |
| pf_line | output | ADDR_W-6 | Line address of the prefetch request |

## Verification
Each load is sampled on a rising edge, and the request it causes, or fails to cause, is visible on the cycle that follows. This is because the table and the output register update on the same edge. The driver applies a load on a falling edge and pushes the expected result into a queue. The monitor pops that entry and compares it one nanosecond after the next rising edge, which is exactly one register stage later. During the stalled-output sequence the queue stays empty. There the bench samples several cycles later to confirm that the held request stays unchanged, and it confirms that a dropped request can be issued again by a later load.

// File: rtl/spf_pkg.sv
package spf_pkg;

   typedef logic [1:0] conf_t;

   localparam conf_t CONF_TOP  = 2'd3;
   localparam conf_t CONF_FIRE = 2'd2;

   function automatic conf_t conf_up(input conf_t c);
      return (c == CONF_TOP) ? c : c + 2'd1;
   endfunction

   function automatic conf_t conf_down(input conf_t c);
      return (c == 2'd0) ? c : c - 2'd1;
   endfunction

endpackage

// File: rtl/spf_match.sv
// Window compare of the incoming line against every tracked stream.
module spf_match #(
   parameter int N          = 4,
   parameter int LINE_W     = 26,
   parameter int SW         = 8,
   parameter int MAX_STRIDE = 64,
   parameter int IW         = 2
) (
   input  logic [N-1:0]             vld,
   input  logic [N-1:0][LINE_W-1:0] last,
   input  logic [LINE_W-1:0]        line,
   output logic                     hit,
   output logic [IW-1:0]            hit_idx,
   output logic [SW-1:0]            delta
);

   localparam logic signed [LINE_W-1:0] WIN = LINE_W'(MAX_STRIDE);

   logic [N-1:0]             near;
   logic [N-1:0][LINE_W-1:0] diff;

   generate
      for (genvar g = 0; g < N; g++) begin : g_cmp
         assign diff[g] = line - last[g];
         assign near[g] = vld[g]
                          && ($signed(diff[g]) <= WIN)
                          && ($signed(diff[g]) >= -WIN);
      end
   endgenerate

   // lowest index wins: scan downwards so it is assigned last
   always_comb begin
      hit     = 1'b0;
      hit_idx = '0;
      delta   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (near[i]) begin
            hit     = 1'b1;
            hit_idx = IW'(i);
            delta   = diff[i][SW-1:0];
         end
      end
   end

endmodule

// File: rtl/spf_lru.sv
// Age-ordered replacement: age 0 is the most recent, age N-1 is the victim.
module spf_lru #(
   parameter int N  = 4,
   parameter int IW = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          touch,
   input  logic [IW-1:0] touch_idx,
   output logic [IW-1:0] victim_idx,
   output logic [N-1:0]  victim_oh
);

   generate
      if (N == 1) begin : g_single
         assign victim_idx = '0;
         assign victim_oh  = 1'b1;
      end else begin : g_ages
         logic [N-1:0][IW-1:0] age;
         logic [IW-1:0]        old_age;

         assign old_age = age[touch_idx];

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int i = 0; i < N; i++) age[i] <= IW'(i);
            end else if (touch) begin
               for (int i = 0; i < N; i++) begin
                  if (IW'(i) == touch_idx) age[i] <= '0;
                  else if (age[i] < old_age) age[i] <= age[i] + 1'b1;
               end
            end
         end

         always_comb begin
            victim_idx = '0;
            for (int i = 0; i < N; i++) begin
               victim_oh[i] = (age[i] == IW'(N - 1));
               if (victim_oh[i]) victim_idx = IW'(i);
            end
         end
      end
   endgenerate

endmodule

// File: rtl/spf_train.sv
// Stride/confidence update and prefetch target for the matched stream.
module spf_train
   import spf_pkg::*;
#(
   parameter int LINE_W  = 26,
   parameter int SW      = 8,
   parameter int PF_DIST = 2
) (
   input  logic [LINE_W-1:0] line,
   input  logic [SW-1:0]     delta,
   input  logic [SW-1:0]     stride_q,
   input  conf_t             conf_q,
   input  logic              pfv_q,
   input  logic [LINE_W-1:0] pf_q,
   output logic [SW-1:0]     stride_d,
   output conf_t             conf_d,
   output logic [LINE_W-1:0] target,
   output logic              fire
);

   localparam logic signed [LINE_W-1:0] DIST_L = LINE_W'(PF_DIST);

   logic                     same_line;
   logic                     repeat_step;
   logic signed [LINE_W-1:0] step;

   assign same_line   = (delta == '0);
   assign repeat_step = !same_line && (delta == stride_q);

   always_comb begin
      stride_d = stride_q;
      conf_d   = conf_q;
      if (repeat_step) begin
         conf_d = conf_up(conf_q);
      end else if (!same_line) begin
         conf_d   = conf_down(conf_q);
         stride_d = delta;
      end
   end

   assign step   = LINE_W'($signed(stride_q));
   assign target = line + LINE_W'(step * DIST_L);
   assign fire   = (same_line || repeat_step)
                   && (conf_d >= CONF_FIRE)
                   && (stride_q != '0)
                   && !(pfv_q && (pf_q == target));

endmodule

// File: rtl/stride_prefetcher.sv
module stride_prefetcher
   import spf_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int LINE_BYTES  = 64,
   parameter int NUM_STREAMS = 4,
   parameter int MAX_STRIDE  = 64,
   parameter int PF_DIST     = 2
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  ld_valid,
   input  logic [ADDR_W-1:0]                     ld_addr,
   output logic                                  pf_valid,
   input  logic                                  pf_ready,
   output logic [ADDR_W-$clog2(LINE_BYTES)-1:0]  pf_line
);

   localparam int OFF    = $clog2(LINE_BYTES);
   localparam int LINE_W = ADDR_W - OFF;
   localparam int SW     = $clog2(MAX_STRIDE + 1) + 1;
   localparam int N      = NUM_STREAMS;
   localparam int IW     = (N > 1) ? $clog2(N) : 1;

   generate
      if ((1 << OFF) != LINE_BYTES || LINE_BYTES < 8) begin : g_bad_line
         $error("LINE_BYTES must be a power of two of at least 8");
      end
      if (N < 1) begin : g_bad_n
         $error("NUM_STREAMS must be at least 1");
      end
      if (MAX_STRIDE < 1 || PF_DIST < 1) begin : g_bad_dist
         $error("MAX_STRIDE and PF_DIST must be at least 1");
      end
      if (LINE_W <= SW) begin : g_bad_w
         $error("ADDR_W too narrow for the stride window");
      end
   endgenerate

   logic [LINE_W-1:0] ld_line;
   logic              unused_offset;
   assign ld_line       = ld_addr[ADDR_W-1:OFF];
   assign unused_offset = ^ld_addr[OFF-1:0];

   // stream table
   logic [N-1:0]             ent_vld;
   logic [N-1:0][LINE_W-1:0] ent_last;
   logic [N-1:0][SW-1:0]     ent_stride;
   conf_t [N-1:0]            ent_conf;
   logic [N-1:0]             ent_pfv;
   logic [N-1:0][LINE_W-1:0] ent_pf;

   logic              hit;
   logic [IW-1:0]     hit_idx;
   logic [SW-1:0]     delta;
   logic [IW-1:0]     victim_idx;
   logic [N-1:0]      victim_oh;
   logic [SW-1:0]     stride_d;
   conf_t             conf_d;
   logic [LINE_W-1:0] target;
   logic              fire;
   logic              accept;
   logic              issue;

   spf_match #(
      .N(N), .LINE_W(LINE_W), .SW(SW), .MAX_STRIDE(MAX_STRIDE), .IW(IW)
   ) u_match (
      .vld     (ent_vld),
      .last    (ent_last),
      .line    (ld_line),
      .hit     (hit),
      .hit_idx (hit_idx),
      .delta   (delta)
   );

   spf_lru #(.N(N), .IW(IW)) u_lru (
      .clk        (clk),
      .rst_n      (rst_n),
      .touch      (ld_valid),
      .touch_idx  (hit ? hit_idx : victim_idx),
      .victim_idx (victim_idx),
      .victim_oh  (victim_oh)
   );

   spf_train #(.LINE_W(LINE_W), .SW(SW), .PF_DIST(PF_DIST)) u_train (
      .line     (ld_line),
      .delta    (delta),
      .stride_q (ent_stride[hit_idx]),
      .conf_q   (ent_conf[hit_idx]),
      .pfv_q    (ent_pfv[hit_idx]),
      .pf_q     (ent_pf[hit_idx]),
      .stride_d (stride_d),
      .conf_d   (conf_d),
      .target   (target),
      .fire     (fire)
   );

   assign accept = !pf_valid || pf_ready;
   assign issue  = ld_valid && hit && fire && accept;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ent_vld    <= '0;
         ent_last   <= '0;
         ent_stride <= '0;
         ent_conf   <= '0;
         ent_pfv    <= '0;
         ent_pf     <= '0;
      end else if (ld_valid) begin
         if (hit) begin
            ent_last[hit_idx]   <= ld_line;
            ent_stride[hit_idx] <= stride_d;
            ent_conf[hit_idx]   <= conf_d;
            if (issue) begin
               ent_pfv[hit_idx] <= 1'b1;
               ent_pf[hit_idx]  <= target;
            end
         end else begin
            ent_vld[victim_idx]    <= 1'b1;
            ent_last[victim_idx]   <= ld_line;
            ent_stride[victim_idx] <= '0;
            ent_conf[victim_idx]   <= '0;
            ent_pfv[victim_idx]    <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pf_valid <= 1'b0;
         pf_line  <= '0;
      end else if (issue) begin
         pf_valid <= 1'b1;
         pf_line  <= target;
      end else if (pf_ready) begin
         pf_valid <= 1'b0;
      end
   end

endmodule

// File: rtl/spf_checker.sv
module spf_checker #(
   parameter int LINE_W     = 26,
   parameter int MAX_STRIDE = 64,
   parameter int PF_DIST    = 2,
   parameter int N          = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ld_valid,
   input logic [LINE_W-1:0] ld_line,
   input logic              pf_valid,
   input logic              pf_ready,
   input logic [LINE_W-1:0] pf_line,
   input logic [N-1:0]      victim_oh
);

   localparam logic signed [LINE_W-1:0] REACH = LINE_W'(MAX_STRIDE * PF_DIST);

   AST_RESET_IDLE: assert property (@(posedge clk)
      !rst_n |=> !pf_valid); // R1

   AST_NEW_REQ_FROM_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (pf_valid && !$past(pf_valid && !pf_ready)) |-> $past(ld_valid)); // R3

   AST_TARGET_REACH: assert property (@(posedge clk) disable iff (!rst_n)
      (pf_valid && !$past(pf_valid && !pf_ready)) |->
         (($signed(pf_line - $past(ld_line)) <= REACH)
          && ($signed(pf_line - $past(ld_line)) >= -REACH)
          && (pf_line != $past(ld_line)))); // R11

   AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
      (pf_valid && !pf_ready) |=> (pf_valid && $stable(pf_line))); // R10

   AST_ONE_VICTIM: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(victim_oh) == 1); // R8

endmodule

bind stride_prefetcher spf_checker #(
   .LINE_W(LINE_W), .MAX_STRIDE(MAX_STRIDE), .PF_DIST(PF_DIST), .N(N)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ld_valid  (ld_valid),
   .ld_line   (ld_line),
   .pf_valid  (pf_valid),
   .pf_ready  (pf_ready),
   .pf_line   (pf_line),
   .victim_oh (victim_oh)
);

// File: tb/stride_prefetcher_tb.sv
module stride_prefetcher_tb;

   localparam int LINE_W = 26;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              ld_valid = 1'b0;
   logic [31:0]       ld_addr = '0;
   logic              pf_ready = 1'b1;
   logic              pf_valid;
   logic [LINE_W-1:0] pf_line;

   int n_chk = 0;
   int n_fail = 0;

   typedef struct {
      logic              v;
      logic [LINE_W-1:0] line;
      string             req;
   } exp_t;

   exp_t exp_q[$];

   always #2 clk = ~clk;

   stride_prefetcher u_dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .ld_valid (ld_valid),
      .ld_addr  (ld_addr),
      .pf_valid (pf_valid),
      .pf_ready (pf_ready),
      .pf_line  (pf_line)
   );

   task automatic judge(input string req, input logic ev, input logic [LINE_W-1:0] el);
      n_chk++;
      if (pf_valid !== ev || (ev && pf_line !== el)) begin
         n_fail++;
         $display("FAIL %s: pf_valid=%0b pf_line=%h, expected pf_valid=%0b pf_line=%h",
                  req, pf_valid, pf_line, ev, el);
      end
   endtask

   // driver: one load, optionally with a scoreboard expectation
   task automatic drive(input logic [LINE_W-1:0] line, input int word, input bit track,
                        input logic ev, input logic [LINE_W-1:0] el, input string req);
      exp_t e;
      @(negedge clk);
      ld_valid = 1'b1;
      ld_addr  = {line, 6'(word * 8)};
      if (track) begin
         e.v = ev; e.line = el; e.req = req;
         exp_q.push_back(e);
      end
      @(negedge clk);
      ld_valid = 1'b0;
   endtask

   task automatic ld_none(input logic [LINE_W-1:0] line, input int word, input string req);
      drive(line, word, 1'b1, 1'b0, '0, req);
   endtask

   task automatic ld_pf(input logic [LINE_W-1:0] line, input int word,
                        input logic [LINE_W-1:0] el, input string req);
      drive(line, word, 1'b1, 1'b1, el, req);
   endtask

   // monitor: result of a load is due one register stage after its edge
   always @(posedge clk) begin
      exp_t e;
      #1;
      if (exp_q.size() != 0) begin
         e = exp_q.pop_front();
         judge(e.req, e.v, e.line);
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      judge("R1", 1'b0, '0);
      rst_n = 1'b1;
      @(negedge clk);
      judge("R1", 1'b0, '0);

      // unit stride, same-line re-touch, duplicate suppression
      ld_none(26'h400, 0, "R1");
      ld_none(26'h400, 1, "R2");
      ld_none(26'h401, 0, "R3");
      ld_none(26'h402, 0, "R3");
      ld_pf  (26'h403, 0, 26'h405, "R3");
      ld_pf  (26'h404, 0, 26'h406, "R11");
      ld_none(26'h404, 1, "R9");

      // stride change lowers confidence, repeat raises it again
      ld_none(26'h407, 0, "R4");
      ld_pf  (26'h40A, 0, 26'h410, "R4");

      // negative stride in a second stream
      ld_none(26'h2000, 0, "R5");
      ld_none(26'h1FFF, 0, "R5");
      ld_none(26'h1FFE, 0, "R5");
      ld_pf  (26'h1FFD, 0, 26'h1FFB, "R5");

      // interleaved streams keep their own state
      ld_pf  (26'h40D, 0, 26'h413, "R7");
      ld_pf  (26'h1FFC, 0, 26'h1FFA, "R7");

      // jumps beyond the window never train
      for (int k = 0; k < 5; k++) ld_none(26'h8000 + 26'(k * 128), 0, "R6");

      // both earlier streams were evicted: continuation retrains from zero
      ld_none(26'h410, 0, "R8");
      ld_none(26'h413, 0, "R8");
      ld_none(26'h416, 0, "R8");
      ld_pf  (26'h419, 0, 26'h41F, "R8");

      // irregular steps inside the window never reach confidence
      ld_none(26'h3000, 0, "R4");
      ld_none(26'h3005, 0, "R4");
      ld_none(26'h3002, 0, "R4");
      ld_none(26'h3009, 0, "R4");
      ld_none(26'h3001, 0, "R4");

      // stalled output: hold, drop, later re-issue
      pf_ready = 1'b0;
      drive(26'h41C, 0, 1'b0, 1'b0, '0, "R10");
      judge("R10", 1'b1, 26'h422);
      repeat (3) @(negedge clk);
      judge("R10", 1'b1, 26'h422);
      drive(26'h41F, 0, 1'b0, 1'b0, '0, "R10");
      judge("R10", 1'b1, 26'h422);
      pf_ready = 1'b1;
      @(negedge clk);
      judge("R10", 1'b0, '0);
      ld_pf  (26'h41F, 3, 26'h425, "R10");
      ld_none(26'h41F, 5, "R9");

      repeat (4) @(negedge clk);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule